// File: doc/BRIEF.md
# Bit-Manipulation ALU

This block is a 32-bit arithmetic and logic unit picked by a 4-bit operation code. It covers the usual add, subtract, bitwise logic and shifts. It also covers rotate-right and an append that builds a constant ten bits at a time. Beyond those it inserts and extracts bit fields in signed or unsigned form, and performs a staged bit-reversal ("flip") that swaps groups of 1, 2, 4, 8 or 16 bits under control of a mask.

Operand B is either a register value or a 10-bit signed immediate that has already been sign-extended upstream. For the field operations, B carries the position in bits 4:0 and the length in bits 8:5, where a length code of zero means sixteen bits. For insert, the bits of B from bit 10 upward supply the value to be written into the field. The arithmetic is combinational and lands in an output register, so every result appears exactly one clock after its inputs. Operation code 15 is undefined and raises an illegal flag.

Top module: `bitalu_top`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0 and `illegal` becomes 0 after that edge.
- R2: `result` and `illegal` are registered: values sampled at one rising edge appear after that edge and hold until the next edge.
- R3: Code 0 gives A+B and code 2 gives A−B, both modulo 2^32.
- R4: Code 4 gives A AND B, code 5 gives A OR B, code 6 gives A XOR B and code 7 gives NOT(A XOR B).
- R5: Code 8 shifts A left, code 9 shifts it right filling with zeros, and code 10 shifts it right filling with copies of bit 31. The amount is B[4:0] in all three cases, and the higher bits of B are ignored.
- R6: Code 1 rotates A right by B[4:0], so an amount of 0 returns A unchanged.
- R7: Code 3 gives (A shifted left by 10) OR (B AND 0x3FF).
- R8: For codes 11 to 13 the field starts at bit B[4:0] and its length is B[8:5]. A length code of 0 means 16. Field bits that would fall above bit 31 are dropped.
- R9: Code 11 writes the low bits of (B >> 10) into the field of A and keeps every other bit of A.
- R10: Code 13 returns the field of A zero-extended. Code 12 returns it sign-extended from its top bit.
- R11: Code 14 takes B bits 0 to 4 in ascending order. When bit k is set, every pair of adjacent 2^k-bit groups in the word is exchanged, so B[4:0]=0 leaves A unchanged and B[4:0]=31 reverses its bits.
- R12: Code 15 sets `illegal` to 1 and `result` to 0. All other codes clear `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B: a register value, or an immediate already sign-extended |
| result | output | 32 | Registered result |
| illegal | output | 1 | Registered flag for an undefined operation code |

## Verification
The checker assumes that `op`, `a` and `b` are stable and known at every rising edge outside reset, and that reset is held from time zero through the first edge. The bench meets this by changing inputs only on falling edges and keeping reset high for several cycles at the start. The random stimulus covers every code, including 15. B is drawn sometimes as a full 32-bit word and sometimes as a sign-extended 10-bit immediate, and field lengths include code 0. Directed cases cover fields that run past bit 31, rotate by zero, the complete flip, and wrap-around on add and subtract.

// File: rtl/bitalu_pkg.sv
package bitalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ROR  = 4'd1,  OP_SUB  = 4'd2,  OP_APP  = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_XNOR = 4'd7,
    OP_SHL  = 4'd8,  OP_SHR  = 4'd9,  OP_SAR  = 4'd10, OP_INS  = 4'd11,
    OP_EXTS = 4'd12, OP_EXTU = 4'd13, OP_FLIP = 4'd14, OP_BAD  = 4'd15
  } alu_op_e;
endpackage

// File: rtl/bitalu_shift.sv
module bitalu_shift #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [$clog2(DW)-1:0] amt,
  output logic [DW-1:0] rot,
  output logic [DW-1:0] shl,
  output logic [DW-1:0] shr,
  output logic [DW-1:0] sar
);
  logic [2*DW-1:0] dbl;

  always_comb begin
    dbl = {a, a} >> amt;
    rot = dbl[DW-1:0];
    shl = a << amt;
    shr = a >> amt;
    sar = $signed(a) >>> amt;
  end
endmodule

// File: rtl/bitalu_field.sv
module bitalu_field #(
  parameter int DW    = 32,
  parameter int LW    = 4,
  parameter int IMM_W = 10
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] ins,
  output logic [DW-1:0] ext_u,
  output logic [DW-1:0] ext_s
);
  localparam int SW = $clog2(DW);
  localparam int ZL = 1 << LW;

  logic [SW-1:0] pos;
  logic [LW-1:0] lcode;
  logic [LW:0]   len;
  logic [DW-1:0] lmask, fmask, src, sh;
  logic          sgn;

  always_comb begin
    pos   = b[SW-1:0];
    lcode = b[SW+LW-1:SW];
    len   = (lcode == '0) ? (LW+1)'(ZL) : {1'b0, lcode};
    if (int'(len) >= DW) lmask = '1;
    else                 lmask = ({{(DW-1){1'b0}}, 1'b1} << len) - 1'b1;
    fmask = lmask << pos;
    src   = b >> IMM_W;
    ins   = (a & ~fmask) | ((src << pos) & fmask);
    sh    = a >> pos;
    ext_u = sh & lmask;
    sgn   = sh[len - 1'b1];
    ext_s = sgn ? (ext_u | ~lmask) : ext_u;
  end
endmodule

// File: rtl/bitalu_flip.sv
module bitalu_flip #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [$clog2(DW)-1:0] sel,
  output logic [DW-1:0] y
);
  localparam int SW = $clog2(DW);

  function automatic logic [DW-1:0] low_mask(input int k);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction

  logic [DW-1:0] stage [0:SW];
  assign stage[0] = a;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam logic [DW-1:0] M = low_mask(k);
    localparam int S = 1 << k;
    assign stage[k+1] = sel[k] ? (((stage[k] & M) << S) | ((stage[k] & ~M) >> S))
                               : stage[k];
  end

  assign y = stage[SW];
endmodule

// File: rtl/bitalu_top.sv
module bitalu_top #(
  parameter int DW    = 32,
  parameter int LW    = 4,
  parameter int IMM_W = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] result,
  output logic          illegal
);
  import bitalu_pkg::*;
  localparam int SW = $clog2(DW);

  logic [DW-1:0] rot, shl, shr, sar, ins, ext_u, ext_s, flp;
  logic [DW-1:0] nxt;
  logic          nxt_bad;

  bitalu_shift #(.DW(DW)) u_shift (
    .a(a), .amt(b[SW-1:0]), .rot(rot), .shl(shl), .shr(shr), .sar(sar)
  );

  bitalu_field #(.DW(DW), .LW(LW), .IMM_W(IMM_W)) u_field (
    .a(a), .b(b), .ins(ins), .ext_u(ext_u), .ext_s(ext_s)
  );

  bitalu_flip #(.DW(DW)) u_flip (
    .a(a), .sel(b[SW-1:0]), .y(flp)
  );

  always_comb begin
    nxt_bad = 1'b0;
    unique case (alu_op_e'(op))
      OP_ADD:  nxt = a + b;
      OP_ROR:  nxt = rot;
      OP_SUB:  nxt = a - b;
      OP_APP:  nxt = (a << IMM_W) | (b & {{(DW-IMM_W){1'b0}}, {IMM_W{1'b1}}});
      OP_AND:  nxt = a & b;
      OP_OR:   nxt = a | b;
      OP_XOR:  nxt = a ^ b;
      OP_XNOR: nxt = ~(a ^ b);
      OP_SHL:  nxt = shl;
      OP_SHR:  nxt = shr;
      OP_SAR:  nxt = sar;
      OP_INS:  nxt = ins;
      OP_EXTS: nxt = ext_s;
      OP_EXTU: nxt = ext_u;
      OP_FLIP: nxt = flp;
      default: begin nxt = '0; nxt_bad = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      illegal <= 1'b0;
    end else begin
      result  <= nxt;
      illegal <= nxt_bad;
    end
  end
endmodule

// File: rtl/bitalu_chk.sv
module bitalu_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    op,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic [DW-1:0] result,
  input logic          illegal
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (result == '0 && !illegal));

  // R12
  bad_op_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd15) |=> (illegal && result == '0));

  // R12
  good_op_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op != 4'd15) |=> !illegal);

  // R6
  rot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd1 && b[4:0] == 5'd0) |=> (result == $past(a)));

  // R7
  append_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd3) |=> (result[9:0] == $past(b[9:0]) && result[31:10] == $past(a[21:0])));

  // R10
  extu_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd13 && b[8:5] == 4'd1) |=> (result[31:1] == '0));

  // R9
  insert_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd11 && b[8:5] == 4'd4 && b[4:0] == 5'd0) |=> (result[31:4] == $past(a[31:4])));

  // R11
  flip_none_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd14 && b[4:0] == 5'd0) |=> (result == $past(a)));
endmodule

bind bitalu_top bitalu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .result(result), .illegal(illegal)
);

// File: tb/tb_bitalu_top.sv
module tb_bitalu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] result;
  logic        illegal;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  bitalu_top dut (.clk(clk), .rst(rst), .op(op), .a(a), .b(b),
                  .result(result), .illegal(illegal));

  function automatic int fld_len(input logic [31:0] bb);
    return (bb[8:5] == 0) ? 16 : int'(bb[8:5]);
  endfunction

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] r;
    int p, l;
    p = int'(y[4:0]);
    l = fld_len(y);
    r = '0;
    case (o)
      0: r = x + y;
      1: for (int i = 0; i < 32; i++) r[i] = x[(i + p) % 32];
      2: r = x - y;
      3: r = {x[21:0], y[9:0]};
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      7: r = ~(x ^ y);
      8: for (int i = 0; i < 32; i++) r[i] = (i >= p) ? x[i - p] : 1'b0;
      9: for (int i = 0; i < 32; i++) r[i] = (i + p < 32) ? x[i + p] : 1'b0;
      10: for (int i = 0; i < 32; i++) r[i] = (i + p < 32) ? x[i + p] : x[31];
      11: for (int i = 0; i < 32; i++)
            r[i] = (i >= p && i < p + l) ? y[10 + i - p] : x[i];
      12, 13: begin
        for (int j = 0; j < l; j++) r[j] = (p + j < 32) ? x[p + j] : 1'b0;
        if (o == 12 && r[l-1]) for (int j = l; j < 32; j++) r[j] = 1'b1;
      end
      14: begin
        r = x;
        for (int k = 0; k < 5; k++) if (y[k]) begin
          logic [31:0] t;
          for (int i = 0; i < 32; i++) t[i] = r[i ^ (1 << k)];
          r = t;
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      0, 2: return "R3";
      1: return "R6";
      3: return "R7";
      4, 5, 6, 7: return "R4";
      8, 9, 10: return "R5";
      11: return "R9 R8";
      12, 13: return "R10 R8";
      14: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    check(tag(o), result, model(o, x, y));
    check("R12 flag", {31'b0, illegal}, {31'b0, o == 4'd15});
  endtask

  function automatic logic [31:0] imm10(input logic [9:0] v);
    return {{22{v[9]}}, v};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed));
    op = 4'd0; a = 32'hFFFF_FFFF; b = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1 result", result, 32'h0);
    check("R1 flag", {31'b0, illegal}, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    apply(4'd15, 32'h1, 32'h2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset after op", result, 32'h0);
    check("R1 reset flag", {31'b0, illegal}, 32'h0);
    rst = 1'b0;

    // R2: output holds until the next rising edge
    apply(4'd6, 32'hA5A5_0F0F, 32'h0FF0_FFFF);
    held = result;
    op = 4'd0; a = 32'h1; b = 32'h1;
    #2;
    check("R2 hold", result, held);
    @(negedge clk);
    check("R2 update", result, 32'h2);

    // directed corner cases
    apply(4'd0, 32'hFFFF_FFFF, 32'h2);
    apply(4'd2, 32'h0, 32'h1);
    apply(4'd7, 32'hF0F0_F0F0, 32'h0F0F_0000);
    apply(4'd1, 32'hDEAD_BEEF, 32'h0000_0020);
    apply(4'd1, 32'h8000_0001, 32'h0000_001F);
    apply(4'd3, 32'hFFC0_0001, imm10(10'h3FF));
    apply(4'd8, 32'h0000_0001, 32'hFFFF_FFE4);
    apply(4'd10, 32'h8000_0000, 32'h0000_003F);
    apply(4'd9, 32'h8000_0000, 32'h0000_001F);
    apply(4'd13, 32'hABCD_1234, 32'h0000_0004);
    apply(4'd12, 32'h0000_8000, 32'h0000_0000);
    apply(4'd12, 32'hF000_0000, 32'h0000_011C);
    apply(4'd13, 32'hF000_0000, 32'h0000_011C);
    apply(4'd11, 32'h1234_5678, 32'hFFFF_F11C);
    apply(4'd11, 32'h0000_0000, 32'h0002_8088);
    apply(4'd14, 32'h0000_0001, 32'h0000_001F);
    apply(4'd14, 32'h1234_5678, 32'h0000_0000);
    apply(4'd14, 32'h1234_5678, 32'h0000_0018);
    apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  o;
      logic [31:0] x, y;
      o = 4'($urandom_range(0, 15));
      x = $urandom;
      y = ($urandom_range(0, 2) == 0) ? imm10(10'($urandom)) : $urandom;
      apply(o, x, y);
    end
    finish_run();
  end
endmodule